// File: doc/BRIEF.md
# Serial Register Port with Streaming Access

This block is a slave serial control port that gives a host read and write access to a bank of byte-wide configuration registers over three wires: an active-low chip select, a serial clock and one bidirectional data line (split into an input, an output and an output-enable). The port oversamples the three pins with the core clock, so every action happens in the core clock domain. The serial clock must be slower than the core clock: each of its high and low phases lasts at least six core clock periods.

Each transfer begins with a 16-bit instruction word, sent most significant bit first. The word holds a direction flag, a two-bit length code and a 13-bit start address. Data bytes follow. Their count is one, two or three, or it is unlimited in streaming mode, which ends only when chip select rises. After each byte the address steps down by one. Addresses that hold no register are still visited in turn and never skipped.

Host writes land in a staging copy of the register bank. The active copy, which drives the configuration outputs, changes only when the host sets the commit bit at a dedicated address. At the end of that transfer every staged byte is copied to the active copy, and the commit bit clears itself. Reads return the staged copy, so the host can check what it has written before it commits.

Top module: `scp_register_port`

## Requirements
- R1: The instruction word is 16 bits, sampled on rising serial clock edges, most significant bit first. Bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code, and bits 12:0 are the start address.
- R2: Length codes 0, 1 and 2 transfer exactly 1, 2 and 3 data bytes. Serial clocks after the last byte write nothing.
- R3: Length code 3 keeps transferring bytes, one per eight serial clocks, until chip select rises.
- R4: The first byte uses the start address, and each later byte uses the address one lower, wrapping from 0 to 0x1FFF. Unimplemented addresses are not skipped: writes to them are dropped, and reads from them return 0x00.
- R5: A data byte is shifted in most significant bit first on rising serial clock edges. A complete byte is written only to the staging copy, and the active outputs do not change until a commit.
- R6: Writing a byte with bit 0 set to address 0x232 arms a commit. In the core cycle after chip select rise is detected, all staged bytes are copied to the active outputs and the commit bit clears. Writing bit 0 as 0 disarms a commit, and a read of 0x232 returns the commit bit in bit 0.
- R7: In a read, the output-enable rises after the 16th instruction clock. Each data bit is driven after a rising edge and held stable through the following falling edge, most significant bit first. The output-enable stays low during the instruction and during writes, and it returns low after chip select rises.
- R8: Raising chip select at any point ends the transfer. A partly received byte or instruction is discarded.
- R9: After reset, all staged and active registers are 0x00, the commit bit is clear and the output-enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdio_in | input | 1 | Serial data line as seen by the port |
| sdio_out | output | 1 | Serial read data driven onto the line |
| sdio_oe | output | 1 | Enable for driving sdio_out onto the line |
| active_regs | output | NUM_REGS*8 | Active register bytes; register i at bits [8i+7:8i] |

## Verification
The assertions check on every cycle that the output-enable falls after deselection, that read data never moves on a detected falling edge, and that no register write happens while deselected. They also check that the active outputs change only right after a transfer ends and that the commit bit is always clear after a transfer end. The other behaviours need the bench's scenarios to show them: decoding of the length codes, descending address order across unimplemented addresses and across the wrap, dropping of aborted bytes, and the exact byte values returned by reads.

// File: rtl/scp_pkg.sv
// Shared types and constants for the serial register port.
// Assumes the protocol widths are fixed: byte-wide data and a 2-bit length code.
package scp_pkg;
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } scp_phase_e;

    localparam int          BYTE_W     = 8;
    localparam logic [1:0]  LEN_STREAM = 2'b11;
endpackage

// File: rtl/scp_pin_sync.sv
// Brings the serial pins into the core clock domain and derives edge events.
// Assumes each serial clock phase lasts well over STAGES+1 core cycles.
// Data is synchronized to the same depth as the clock, so they stay aligned.
module scp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdio_in,
    output logic cs_hi,
    output logic end_evt,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdio_s
);
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] sdio_pipe;
    logic              cs_d;
    logic              sclk_d;

    // Synchronizer chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_pipe   <= '1;
            sclk_pipe <= '0;
            sdio_pipe <= '0;
            cs_d      <= 1'b1;
            sclk_d    <= 1'b0;
        end else begin
            cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n};
            sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
            sdio_pipe <= {sdio_pipe[STAGES-2:0], sdio_in};
            cs_d      <= cs_pipe[STAGES-1];
            sclk_d    <= sclk_pipe[STAGES-1];
        end
    end

    // Edge events in the core domain.
    assign cs_hi     = cs_pipe[STAGES-1];
    assign end_evt   = cs_pipe[STAGES-1] & ~cs_d;
    assign sclk_rise = sclk_pipe[STAGES-1] & ~sclk_d & ~cs_pipe[STAGES-1];
    assign sclk_fall = ~sclk_pipe[STAGES-1] & sclk_d & ~cs_pipe[STAGES-1];
    assign sdio_s    = sdio_pipe[STAGES-1];
endmodule

// File: rtl/scp_engine.sv
// Serial protocol engine: decodes the instruction word, counts data bytes,
// steps the address downward and drives the register-file bus.
// Assumes synchronized edge events from scp_pin_sync and a combinational
// read path on the bus. Read data is loaded one core cycle after a byte boundary.
module scp_engine
    import scp_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              sclk_rise,
    input  logic              sdio_s,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              sdio_out,
    output logic              sdio_oe
);
    localparam int           HDR_W    = ADDR_W + 3;
    localparam int           CNT_W    = $clog2(HDR_W);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

    scp_phase_e        phase;
    logic [CNT_W-1:0]  cnt;
    logic [HDR_W-2:0]  hdr_sr;
    logic [HDR_W-1:0]  hdr_full;
    logic              is_read;
    logic              stream;
    logic [1:0]        bytes_left;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-2:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              load_pend;
    logic              byte_done;

    assign hdr_full  = {hdr_sr, sdio_s};
    assign byte_done = sclk_rise && (phase == PH_DATA) && (cnt == BIT_LAST);

    // Protocol state machine advanced on synchronized rising serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_HDR;
            cnt        <= '0;
            hdr_sr     <= '0;
            is_read    <= 1'b0;
            stream     <= 1'b0;
            bytes_left <= '0;
            cur_addr   <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            load_pend  <= 1'b0;
            sdio_oe    <= 1'b0;
        end else if (cs_hi) begin
            phase     <= PH_HDR;
            cnt       <= '0;
            load_pend <= 1'b0;
            sdio_oe   <= 1'b0;
        end else begin
            if (load_pend) begin
                tx_sr     <= bus_rdata;
                load_pend <= 1'b0;
            end
            if (sclk_rise) begin
                case (phase)
                    PH_HDR: begin
                        if (cnt == HDR_LAST) begin
                            is_read    <= hdr_full[HDR_W-1];
                            stream     <= (hdr_full[HDR_W-2 -: 2] == LEN_STREAM);
                            bytes_left <= hdr_full[HDR_W-2 -: 2];
                            cur_addr   <= hdr_full[ADDR_W-1:0];
                            load_pend  <= hdr_full[HDR_W-1];
                            sdio_oe    <= hdr_full[HDR_W-1];
                            cnt        <= '0;
                            phase      <= PH_DATA;
                        end else begin
                            hdr_sr <= hdr_full[HDR_W-2:0];
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (cnt == BIT_LAST) begin
                            cnt      <= '0;
                            cur_addr <= cur_addr - 1'b1;
                            if (!stream && bytes_left == 2'd0) begin
                                phase <= PH_DONE;
                            end else begin
                                if (!stream) begin
                                    bytes_left <= bytes_left - 1'b1;
                                end
                                load_pend <= is_read;
                            end
                        end else begin
                            cnt   <= cnt + 1'b1;
                            rx_sr <= {rx_sr[BYTE_W-3:0], sdio_s};
                            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Register-file bus: write strobe on the last bit of each written byte.
    assign bus_addr  = cur_addr;
    assign bus_wdata = {rx_sr, sdio_s};
    assign bus_we    = byte_done && !is_read;
    assign sdio_out  = tx_sr[BYTE_W-1];
endmodule

// File: rtl/scp_regbank.sv
// Staged and active register bank with a commit bit.
// Assumes at most one bus write per cycle and that writes and transfer end
// never coincide, since writes happen only while selected.
module scp_regbank
    import scp_pkg::*;
#(
    parameter int              ADDR_W      = 13,
    parameter int              NUM_REGS    = 16,
    parameter logic [ADDR_W-1:0] COMMIT_ADDR = 13'h232
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [BYTE_W-1:0]          bus_wdata,
    input  logic                       bus_we,
    input  logic                       end_evt,
    output logic [BYTE_W-1:0]          bus_rdata,
    output logic                       upd_flag,
    output logic [NUM_REGS*BYTE_W-1:0] active_regs
);
    localparam int               IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

    logic [BYTE_W-1:0] staged [NUM_REGS];
    logic [BYTE_W-1:0] active [NUM_REGS];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = (bus_addr <= LAST_IDX);
    assign idx      = bus_addr[IDX_W-1:0];

    // Staging writes, commit arming and the end-of-transfer copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                staged[i] <= '0;
                active[i] <= '0;
            end
            upd_flag <= 1'b0;
        end else if (end_evt) begin
            if (upd_flag) begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    active[i] <= staged[i];
                end
            end
            upd_flag <= 1'b0;
        end else if (bus_we) begin
            if (in_range) begin
                staged[idx] <= bus_wdata;
            end
            if (bus_addr == COMMIT_ADDR) begin
                upd_flag <= bus_wdata[0];
            end
        end
    end

    // Read mux: staged bytes, the commit bit, or zero for empty addresses.
    always_comb begin
        if (in_range) begin
            bus_rdata = staged[idx];
        end else if (bus_addr == COMMIT_ADDR) begin
            bus_rdata = {{(BYTE_W-1){1'b0}}, upd_flag};
        end else begin
            bus_rdata = '0;
        end
    end

    // Flatten the active copy onto the output vector.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign active_regs[g*BYTE_W +: BYTE_W] = active[g];
    end
endmodule

// File: rtl/scp_register_port.sv
// Top of the serial register port: pin synchronizer, protocol engine and
// staged register bank. Assumes a serial clock much slower than clk.
module scp_register_port
    import scp_pkg::*;
#(
    parameter int                ADDR_W      = 13,
    parameter int                NUM_REGS    = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] COMMIT_ADDR = 13'h232
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       sdio_in,
    output logic                       sdio_out,
    output logic                       sdio_oe,
    output logic [NUM_REGS*BYTE_W-1:0] active_regs
);
    logic              cs_hi;
    logic              end_evt;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              sdio_s;
    logic [ADDR_W-1:0] bus_addr;
    logic [BYTE_W-1:0] bus_wdata;
    logic [BYTE_W-1:0] bus_rdata;
    logic              bus_we;
    logic              upd_flag;

    scp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdio_in   (sdio_in),
        .cs_hi     (cs_hi),
        .end_evt   (end_evt),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdio_s    (sdio_s)
    );

    scp_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_hi     (cs_hi),
        .sclk_rise (sclk_rise),
        .sdio_s    (sdio_s),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe)
    );

    scp_regbank #(
        .ADDR_W      (ADDR_W),
        .NUM_REGS    (NUM_REGS),
        .COMMIT_ADDR (COMMIT_ADDR)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .end_evt     (end_evt),
        .bus_rdata   (bus_rdata),
        .upd_flag    (upd_flag),
        .active_regs (active_regs)
    );
endmodule

// File: rtl/scp_checker.sv
// Protocol and commit checks for scp_register_port, attached by bind.
// Assumes the serial clock timing stated for the top module.
module scp_checker #(
    parameter int WIDTH = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_hi,
    input logic             sclk_fall,
    input logic             end_evt,
    input logic             bus_we,
    input logic             upd_flag,
    input logic             sdio_out,
    input logic             sdio_oe,
    input logic [WIDTH-1:0] active_regs
);
    // R9: reset leaves the outputs idle and cleared.
    a_r9_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!sdio_oe && active_regs == '0));

    // R7: output-enable is released once the port is deselected.
    a_r7_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !sdio_oe);

    // R7: read data is stable across each detected falling edge.
    a_r7_stable_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && sdio_oe) |-> $stable(sdio_out));

    // R5: the active copy moves only right after a transfer ends.
    a_r5_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !end_evt |=> $stable(active_regs));

    // R6: the commit bit is clear after every transfer end.
    a_r6_update_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |=> !upd_flag);

    // R8: no register write happens while deselected.
    a_r8_write_selected: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> !cs_hi);
endmodule

bind scp_register_port scp_checker #(.WIDTH(NUM_REGS*8)) u_scp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_hi       (cs_hi),
    .sclk_fall   (sclk_fall),
    .end_evt     (end_evt),
    .bus_we      (bus_we),
    .upd_flag    (upd_flag),
    .sdio_out    (sdio_out),
    .sdio_oe     (sdio_oe),
    .active_regs (active_regs)
);

// File: tb/test_scp_register_port.sv
// Bench for scp_register_port: drives serial transfers and checks register
// contents and read data against a model built from the requirements.
module test_scp_register_port;
    localparam int NREG = 16;
    localparam int HALF = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs_n = 1'b1;
    logic            sclk = 1'b0;
    logic            sdio_in = 1'b0;
    logic            sdio_out;
    logic            sdio_oe;
    logic [NREG*8-1:0] active_regs;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0]      wbytes [0:31];
    logic            rbits  [0:255];
    bit              hdr_oe_seen;
    bit              data_oe_all;
    bit              data_oe_any;
    logic [NREG*8-1:0] snap_active;
    logic [7:0]      exp_staged [0:NREG-1];
    logic [7:0]      exp_active [0:NREG-1];
    bit              exp_upd;

    always #10 clk = ~clk;

    scp_register_port i_scp_register_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdio_in     (sdio_in),
        .sdio_out    (sdio_out),
        .sdio_oe     (sdio_oe),
        .active_regs (active_regs)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One transfer of nslots serial clocks; captures the line before each fall.
    task automatic xfer(input bit rd, input logic [1:0] len, input logic [12:0] addr,
                        input int nslots);
        logic [15:0] hdr;
        hdr = {rd, len, addr};
        hdr_oe_seen = 0;
        data_oe_all = 1;
        data_oe_any = 0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int n = 1; n <= nslots; n++) begin
            if (n <= 16) sdio_in = hdr[16-n];
            else sdio_in = wbytes[(n-17)/8][7-((n-17)%8)];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (n < 16) hdr_oe_seen |= sdio_oe;
            else if (n - 16 < 256) begin
                rbits[n-16] = sdio_out;
                data_oe_all &= sdio_oe;
                data_oe_any |= sdio_oe;
            end
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        snap_active = active_regs;
        cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    function automatic logic [7:0] rbyte(input int b);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = rbits[8*b + 7 - i];
        return v;
    endfunction

    // Model of the staging side for a write of nslots clocks.
    task automatic model_write(input logic [1:0] len, input logic [12:0] addr,
                               input int nslots);
        int nb;
        logic [12:0] a;
        nb = (nslots >= 16) ? (nslots - 16) / 8 : 0;
        for (int k = 0; k < nb; k++) begin
            if (len != 2'b11 && k > int'(len)) break;
            a = addr - 13'(k);
            if (a < 13'(NREG)) exp_staged[a[3:0]] = wbytes[k];
            if (a == 13'h232) exp_upd = wbytes[k][0];
        end
        if (exp_upd) begin
            for (int i = 0; i < NREG; i++) exp_active[i] = exp_staged[i];
            exp_upd = 0;
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [12:0] a);
        if (a < 13'(NREG)) return exp_staged[a[3:0]];
        return 8'h00;
    endfunction

    task automatic check_active(input string req);
        for (int i = 0; i < NREG; i++)
            chk(active_regs[i*8 +: 8] == exp_active[i], req, active_regs[i*8 +: 8],
                exp_active[i]);
    endtask

    task automatic wr(input logic [1:0] len, input logic [12:0] addr, input int nslots);
        xfer(1'b0, len, addr, nslots);
        model_write(len, addr, nslots);
        chk(!data_oe_any && !hdr_oe_seen, "R7 oe low in write", data_oe_any, 0);
    endtask

    // Read nb bytes starting at addr and compare against the model.
    task automatic rd_check(input logic [1:0] len, input logic [12:0] addr, input int nb,
                            input string req);
        xfer(1'b1, len, addr, 16 + 8 * nb);
        chk(!hdr_oe_seen, "R7 oe low in header", hdr_oe_seen, 0);
        chk(data_oe_all, "R7 oe high in read data", data_oe_all, 1);
        chk(!sdio_oe, "R7 oe released after cs", sdio_oe, 0);
        for (int b = 0; b < nb; b++)
            chk(rbyte(b) == exp_read(addr - 13'(b)), req, rbyte(b), exp_read(addr - 13'(b)));
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            exp_staged[i] = 8'h00;
            exp_active[i] = 8'h00;
        end
        exp_upd = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9: reset state
        chk(active_regs == '0, "R9 active after reset", active_regs, 0);
        chk(!sdio_oe, "R9 oe after reset", sdio_oe, 0);
        rd_check(2'b00, 13'd0, 1, "R9 staged after reset");

        // R1 R5: single write lands in staging only
        wbytes[0] = 8'hA5;
        wr(2'b00, 13'd3, 24);
        chk(snap_active == '0, "R5 active before cs rise", snap_active, 0);
        check_active("R5 active unchanged after write");
        rd_check(2'b00, 13'd3, 1, "R1 single read back");

        // R2: length code 2 with a fourth byte clocked
        wbytes[0] = 8'h11; wbytes[1] = 8'h22; wbytes[2] = 8'h33; wbytes[3] = 8'h44;
        wr(2'b10, 13'd10, 16 + 32);
        rd_check(2'b11, 13'd10, 4, "R2 three bytes only, R3 stream read");
        rd_check(2'b01, 13'd10, 2, "R2 two-byte read");

        // R4: sweep all registers with single writes, then stream read across gap
        for (int a = 0; a < NREG; a++) begin
            wbytes[0] = 8'(a * 29 + 7);
            wr(2'b00, 13'(a), 24);
        end
        rd_check(2'b11, 13'(NREG + 2), NREG + 4, "R4 descending stream with empty addresses");

        // R4 R3: stream write across the wrap from 0 to 0x1FFF
        wbytes[0] = 8'hC1; wbytes[1] = 8'hC0; wbytes[2] = 8'hEE;
        wr(2'b11, 13'd1, 16 + 24);
        rd_check(2'b11, 13'd1, 3, "R4 wrap to 0x1FFF");

        // R6: commit copies staging to active and self-clears
        check_active("R5 active still reset before commit");
        wbytes[0] = 8'h01;
        wr(2'b00, 13'h232, 24);
        chk(snap_active == '0, "R6 no copy before cs rise", snap_active, 0);
        check_active("R6 active equals staging after commit");
        xfer(1'b1, 2'b00, 13'h232, 24);
        chk(rbyte(0) == 8'h00, "R6 commit bit self-cleared", rbyte(0), 0);

        // R6: disarming write does not commit
        wbytes[0] = 8'h5A;
        wr(2'b00, 13'd4, 24);
        wbytes[0] = 8'h00;
        wr(2'b00, 13'h232, 24);
        check_active("R6 no commit with bit 0 clear");
        // R6: commit armed in the second byte of a stream from 0x233
        wbytes[0] = 8'hFF; wbytes[1] = 8'h01;
        wr(2'b11, 13'h233, 16 + 16);
        check_active("R6 commit via stream");

        // R8: aborts mid-byte and mid-instruction
        wbytes[0] = 8'h99;
        wr(2'b00, 13'd5, 16 + 5);
        rd_check(2'b00, 13'd5, 1, "R8 partial byte dropped");
        wr(2'b00, 13'd6, 10);
        rd_check(2'b00, 13'd6, 1, "R8 partial instruction dropped");
        wbytes[0] = 8'h3C; wbytes[1] = 8'hC3;
        wr(2'b01, 13'd8, 16 + 11);
        rd_check(2'b01, 13'd8, 2, "R8 first byte kept second dropped");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule